// File: doc/BRIEF.md
# Serial Receiver with 64-Entry Queue and Fill-Driven Ready-to-Send

This block takes an asynchronous serial input, recovers bytes from it and keeps them in a 64-entry receive queue. It also drives an active-low ready-to-send line, so the far end stops sending before the queue fills.

Each frame has a low start bit, eight data bits sent least significant bit first, an optional parity bit and a high stop bit. Bit timing comes from a 16x sample enable that a baud generator outside the block supplies. Every byte that completes a frame is queued together with a parity-error flag and a framing-error flag. A byte that arrives while the queue is full is lost, and this sets a sticky overrun flag.

The ready-to-send line goes low (the receiver can accept data) only under three conditions: flow control is enabled, the receiver is enabled, and the queue holds fewer bytes than a threshold. A 3-bit select picks that threshold. The line is recomputed on every clock from the current fill level.

The receive engine is a state machine with these states:
- `RX_IDLE` waits for a low line.
- `RX_START` checks the start bit at mid-bit. If the line is high again it goes back to `RX_IDLE` (false start). If the line is still low it goes to `RX_DATA`.
- `RX_DATA` samples the eight data bits. After the eighth bit it goes to `RX_PARITY` when parity is enabled, or to `RX_STOP` when it is not.
- `RX_PARITY` samples the parity bit and then goes to `RX_STOP`.
- `RX_STOP` samples the stop bit, writes the byte to the queue and goes back to `RX_IDLE`.

Clearing the receiver enable forces the machine back to `RX_IDLE` from any state.

Top module: `uart_rx_rts_fifo`

## Requirements
- R1: A frame is recovered as a low start bit, then data bits D0 to D7 in that order, then an optional parity bit, then a stop bit. The byte appears on `rd_data` with bit 0 equal to D0.
- R2: Each bit is sampled 8 sample enables after its leading edge (the middle of its 16-enable window). A low pulse that has ended before the middle of the start bit is rejected, and nothing is queued.
- R3: When `par_en` is 1, a parity bit follows D7. The expected parity bit is the XOR of D0 to D7, and it is inverted when `par_odd` is 1. A mismatch sets `rd_perr` for that byte, and the byte is still queued. When `par_en` is 0, `rd_perr` is 0.
- R4: A stop bit sampled as 0 sets `rd_ferr` for that byte, and the byte is still queued.
- R5: The queue holds up to 64 bytes and returns them in arrival order. `rd_valid` is 1 when `fill` is nonzero. A 1 on `rd_take` while `rd_valid` is 1 removes the head entry. `fill` gives the number of entries held.
- R6: A byte that completes while 64 entries are held is discarded. This sets `overrun`, and `overrun` stays at 1 until reset.
- R7: `rts_sel` codes 0 to 7 select the thresholds 15, 1, 4, 6, 8, 10, 12 and 14.
- R8: With `flow_en` = 1 and `rx_en` = 1, `rts_n` is 1 when `fill` is greater than or equal to the selected threshold, and 0 otherwise (so it is 0 when the queue is empty). It follows `fill` and the select one clock later.
- R9: With `rx_en` = 0, `rts_n` is 1, the receiver stays in `RX_IDLE`, and no byte is queued.
- R10: With `flow_en` = 0, `rts_n` is 1.
- R11: After reset, `fill` is 0, `rd_valid` is 0, `overrun` is 0 and `rts_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample enable at 16 times the bit rate |
| rxd | input | 1 | Serial data line, idle high |
| rx_en | input | 1 | Receiver enable |
| par_en | input | 1 | Parity bit present in frame |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rts_sel | input | 3 | Ready-to-send threshold select |
| flow_en | input | 1 | Flow-control enable |
| rd_data | output | 8 | Head-of-queue byte |
| rd_perr | output | 1 | Parity error flag of head entry |
| rd_ferr | output | 1 | Framing error flag of head entry |
| rd_valid | output | 1 | Queue not empty |
| rd_take | input | 1 | Remove head entry |
| fill | output | 7 | Number of queued entries |
| overrun | output | 1 | Sticky overrun flag |
| rts_n | output | 1 | Ready-to-send, active low |

## Verification
Input passes through a two-stage synchronizer, and each byte is queued at the clock edge that samples the middle of its stop bit. `fill` therefore changes well inside the stop bit, and the bench checks it only after a full stop-bit period plus one idle bit period. `rts_n` is registered, so it lags `fill`, `rts_sel`, `flow_en` and `rx_en` by one clock; the bench waits two clock edges after any such change before sampling. A removal via `rd_take` updates `fill` and the head entry at the next edge, and all outputs are sampled on the falling clock edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_t;

    typedef struct packed {
        logic       perr;
        logic       ferr;
        logic [7:0] data;
    } rx_word_t;

    // Threshold table for the ready-to-send select (R7)
    function automatic int rts_threshold(input logic [2:0] code);
        if (code == 3'd0)
            return 15;
        else if (code == 3'd1)
            return 1;
        else
            return 2 * int'(code);
    endfunction

endpackage

// File: rtl/rx_frame.sv
module rx_frame
    import rxq_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     rxd,
    input  logic     rx_en,
    input  logic     par_en,
    input  logic     par_odd,
    output logic     push,
    output rx_word_t word
);
    localparam int             CW   = $clog2(OSR);
    localparam logic [CW-1:0]  MIDC = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0]  LSTC = CW'(OSR - 1);

    rx_state_t  st, st_nx;
    logic [1:0] sync_q;
    logic       rxs;
    logic [CW-1:0] cnt;
    logic [2:0] bidx;
    logic [7:0] shreg;
    logic       pbit;

    assign rxs = sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        if (!rx_en) begin
            st_nx = RX_IDLE;
        end else if (tick) begin
            unique case (st)
                RX_IDLE:   if (!rxs) st_nx = RX_START;
                RX_START:  if (cnt == MIDC) st_nx = rxs ? RX_IDLE : RX_DATA;
                RX_DATA:   if (cnt == LSTC && bidx == 3'd7)
                               st_nx = par_en ? RX_PARITY : RX_STOP;
                RX_PARITY: if (cnt == LSTC) st_nx = RX_STOP;
                RX_STOP:   if (cnt == LSTC) st_nx = RX_IDLE;
                default:   st_nx = RX_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            bidx  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
            push  <= 1'b0;
            word  <= '0;
        end else begin
            push <= 1'b0;
            if (!rx_en) begin
                cnt  <= '0;
                bidx <= '0;
            end else if (tick) begin
                if (st_nx != st || cnt == LSTC) cnt <= '0;
                else                            cnt <= cnt + 1'b1;
                unique case (st)
                    RX_IDLE:  bidx <= '0;
                    RX_START: bidx <= '0;
                    RX_DATA: begin
                        if (cnt == LSTC) begin
                            shreg <= {rxs, shreg[7:1]};
                            bidx  <= bidx + 1'b1;
                        end
                    end
                    RX_PARITY: begin
                        if (cnt == LSTC) pbit <= rxs;
                    end
                    RX_STOP: begin
                        if (cnt == LSTC) begin
                            push      <= 1'b1;
                            word.data <= shreg;
                            word.ferr <= ~rxs;
                            word.perr <= par_en & (pbit ^ (^shreg) ^ par_odd);
                        end
                    end
                    default: bidx <= '0;
                endcase
            end
        end
    end

    // R9
    rx_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> st == RX_IDLE);

    // R1
    push_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $past(st) == RX_STOP);

    // R3
    no_perr_wo_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !$past(par_en)) |-> !word.perr);

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  rx_word_t                   wr_word,
    input  logic                       pop,
    output rx_word_t                   rd_word,
    output logic                       rd_valid,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       overrun
);
    localparam int            AW   = $clog2(DEPTH);
    localparam int            CW   = AW + 1;
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    rx_word_t      mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          acc, take;

    assign acc      = push && (count != FULL);
    assign take     = pop && (count != '0);
    assign rd_valid = (count != '0);
    assign rd_word  = mem[rptr];

    always_ff @(posedge clk) begin
        if (acc) mem[wptr] <= wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (acc)  wptr <= wptr + 1'b1;
            if (take) rptr <= rptr + 1'b1;
            if (acc && !take)      count <= count + 1'b1;
            else if (take && !acc) count <= count - 1'b1;
            if (push && !acc) overrun <= 1'b1;
        end
    end

    // R6
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL && push && !pop) |=> (count == FULL && overrun));

    // R5
    pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count != '0) |=> count == $past(count) - 1'b1);

endmodule

// File: rtl/rts_ctrl.sv
module rts_ctrl
    import rxq_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic [2:0]    sel,
    input  logic          flow_en,
    input  logic          rx_en,
    output logic          rts_n
);
    logic hold;

    assign hold = !flow_en || !rx_en || (int'(count) >= rts_threshold(sel));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rts_n <= 1'b1;
        else        rts_n <= hold;
    end

    // R9
    rts_rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> rts_n);

    // R10
    rts_flow_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_en |=> rts_n);

    // R8
    rts_empty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && flow_en && count == '0) |=> !rts_n);

endmodule

// File: rtl/uart_rx_rts_fifo.sv
module uart_rx_rts_fifo
    import rxq_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick16,
    input  logic                    rxd,
    input  logic                    rx_en,
    input  logic                    par_en,
    input  logic                    par_odd,
    input  logic [2:0]              rts_sel,
    input  logic                    flow_en,
    output logic [7:0]              rd_data,
    output logic                    rd_perr,
    output logic                    rd_ferr,
    output logic                    rd_valid,
    input  logic                    rd_take,
    output logic [$clog2(DEPTH):0]  fill,
    output logic                    overrun,
    output logic                    rts_n
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic     push;
    rx_word_t wword, rword;

    rx_frame #(.OSR(OSR)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .rxd     (rxd),
        .rx_en   (rx_en),
        .par_en  (par_en),
        .par_odd (par_odd),
        .push    (push),
        .word    (wword)
    );

    rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .wr_word  (wword),
        .pop      (rd_take),
        .rd_word  (rword),
        .rd_valid (rd_valid),
        .count    (fill),
        .overrun  (overrun)
    );

    rts_ctrl #(.CW(CW)) u_rts (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (fill),
        .sel     (rts_sel),
        .flow_en (flow_en),
        .rx_en   (rx_en),
        .rts_n   (rts_n)
    );

    assign rd_data = rword.data;
    assign rd_perr = rword.perr;
    assign rd_ferr = rword.ferr;

endmodule

// File: tb/uart_rx_rts_fifo_bench.sv
module uart_rx_rts_fifo_bench;
    localparam int BITP = 32; // clocks per bit: sample enable every 2 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic [2:0] rts_sel = 3'd0;
    logic       flow_en = 1'b0;
    logic       rd_take = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_valid, overrun, rts_n;
    logic [6:0] fill;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    uart_rx_rts_fifo u_uart_rx_rts_fifo (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
        .par_en(par_en), .par_odd(par_odd), .rts_sel(rts_sel), .flow_en(flow_en),
        .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
        .rd_valid(rd_valid), .rd_take(rd_take), .fill(fill),
        .overrun(overrun), .rts_n(rts_n)
    );

    always #4 clk = ~clk;
    always @(posedge clk) tick16 <= ~tick16;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int thr_of(input logic [2:0] c);
        case (c)
            3'd0: return 15;  3'd1: return 1;  3'd2: return 4;  3'd3: return 6;
            3'd4: return 8;   3'd5: return 10; 3'd6: return 12; default: return 14;
        endcase
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // stop_bad: stop bit low for 20 clocks (past mid-bit), then high
    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop_bad);
        rxd = 1'b0; wait_clk(BITP);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i]; wait_clk(BITP);
        end
        if (par_en) begin
            rxd = (^d) ^ par_odd ^ bad_par; wait_clk(BITP);
        end
        if (stop_bad) begin
            rxd = 1'b0; wait_clk(20); rxd = 1'b1; wait_clk(BITP - 20);
        end else begin
            rxd = 1'b1; wait_clk(BITP);
        end
        rxd = 1'b1; wait_clk(BITP);
    endtask

    task automatic take_one();
        rd_take = 1'b1; wait_clk(1); rd_take = 1'b0; wait_clk(1);
    endtask

    task automatic t_reset();
        check("R11 fill", int'(fill), 0);
        check("R11 rd_valid", int'(rd_valid), 0);
        check("R11 overrun", int'(overrun), 0);
        check("R11 rts_n", int'(rts_n), 1);
    endtask

    task automatic t_basic();
        send_frame(8'hA5, 0, 0);
        check("R1 fill", int'(fill), 1);
        check("R1 data A5", int'(rd_data), 8'hA5);
        check("R5 rd_valid", int'(rd_valid), 1);
        send_frame(8'h3C, 0, 0);
        check("R5 fill two", int'(fill), 2);
        take_one();
        check("R5 order head 3C", int'(rd_data), 8'h3C);
        check("R4 ferr clean", int'(rd_ferr), 0);
        take_one();
        check("R5 drained", int'(rd_valid), 0);
    endtask

    task automatic t_parity();
        par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'h17, 0, 0);
        check("R3 even ok", int'(rd_perr), 0);
        take_one();
        send_frame(8'h17, 1, 0);
        check("R3 even bad", int'(rd_perr), 1);
        check("R3 data kept", int'(rd_data), 8'h17);
        take_one();
        par_odd = 1'b1;
        send_frame(8'hC8, 0, 0);
        check("R3 odd ok", int'(rd_perr), 0);
        take_one();
        send_frame(8'hC8, 1, 0);
        check("R3 odd bad", int'(rd_perr), 1);
        take_one();
        par_en = 1'b0; par_odd = 1'b0;
    endtask

    task automatic t_framing();
        send_frame(8'h5A, 0, 1);
        wait_clk(BITP);
        check("R4 fill", int'(fill), 1);
        check("R4 ferr", int'(rd_ferr), 1);
        check("R4 data kept", int'(rd_data), 8'h5A);
        take_one();
        check("R4 no extra frame", int'(fill), 0);
    endtask

    task automatic t_false_start();
        rxd = 1'b0; wait_clk(6); rxd = 1'b1;
        wait_clk(4 * BITP);
        check("R2 glitch rejected", int'(fill), 0);
        send_frame(8'h81, 0, 0);
        check("R2 next frame ok", int'(rd_data), 8'h81);
        take_one();
    endtask

    task automatic t_disabled();
        flow_en = 1'b1; rx_en = 1'b0;
        wait_clk(2);
        check("R9 rts off", int'(rts_n), 1);
        send_frame(8'hFF, 0, 0);
        check("R9 nothing queued", int'(fill), 0);
        rx_en = 1'b1; wait_clk(2);
        check("R8 empty rts low", int'(rts_n), 0);
    endtask

    task automatic t_rts_levels();
        rts_sel = 3'd2;
        for (int i = 0; i < 4; i++) begin
            send_frame(8'(i + 1), 0, 0);
            check("R8 rts vs fill sel2", int'(rts_n), ((i + 1) >= thr_of(3'd2)) ? 1 : 0);
        end
        take_one(); wait_clk(1);
        check("R8 rts drops after take", int'(rts_n), 0);
        rts_sel = 3'd1; wait_clk(2);
        check("R7 sel1 threshold 1", int'(rts_n), 1);
        rts_sel = 3'd7; wait_clk(2);
        check("R7 sel7 threshold 14", int'(rts_n), 0);
        rts_sel = 3'd3; wait_clk(2);
        check("R7 sel3 threshold 6", int'(rts_n), 0);
        flow_en = 1'b0; wait_clk(2);
        check("R10 flow off", int'(rts_n), 1);
        flow_en = 1'b1;
        rx_en = 1'b0; wait_clk(2);
        check("R9 rx off forces high", int'(rts_n), 1);
        rx_en = 1'b1;
        for (int i = 0; i < 3; i++) take_one();
        check("R5 empty again", int'(fill), 0);
    endtask

    task automatic t_overrun();
        rts_sel = 3'd0; flow_en = 1'b1;
        for (int i = 0; i < 65; i++) begin
            send_frame(8'(i * 3 + 7), 0, 0);
            if (i == 13) check("R8 fill14 sel0 low", int'(rts_n), 0);
            if (i == 14) check("R7 fill15 sel0 high", int'(rts_n), 1);
            if (i == 63) check("R6 no overrun at 64", int'(overrun), 0);
        end
        check("R6 fill capped", int'(fill), 64);
        check("R6 overrun set", int'(overrun), 1);
        for (int i = 0; i < 64; i++) begin
            check("R5 order", int'(rd_data), (i * 3 + 7) % 256);
            take_one();
        end
        check("R5 final empty", int'(fill), 0);
        check("R6 overrun sticky", int'(overrun), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        t_reset();
        rst_n = 1'b1;
        wait_clk(4);
        t_basic();
        t_parity();
        t_framing();
        t_false_start();
        t_disabled();
        t_rts_levels();
        t_overrun();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule